// File: doc/BRIEF.md
# Multi-Bit-Per-Clock First-Order Pulse-Density Modulator

This block turns a 16-bit unsigned sample into a one-bit pulse-density stream, computing several output bits in every fabric clock. It evaluates the first-order error recurrence once for each bit slot within a single clock. It places the bits side by side in a parallel word, which a downstream serializer shifts out at a multiple of the logic clock. The averaged density of ones in the stream tracks the ratio of the sample to 2^16. An analog low-pass filter after the pin then recovers the waveform.

Each clock the block reads the sample and the state left behind by the previous clock. It runs `LANES` chained decision steps and registers both the resulting word and the final state. The bit sequence therefore matches that of a one-bit-per-clock modulator clocked `LANES` times faster. The enable input also serves as the block's asynchronous clear.

Top module: `pdm_par_modulator`

## Requirements
- R1: Each clock produces `LANES` output bits. Bit 0 of `pdm_word` is the earliest in time and bit `LANES-1` the latest. Across clocks, the concatenated stream is identical bit for bit to a serial modulator that executes one step per bit.
- R2: At every step the decided bit is 1 exactly when the sample, compared as unsigned, is greater than or equal to the current 16-bit error value; otherwise it is 0.
- R3: The 16-bit feedback value is 0xFFFF after a step that decided 1 and 0x0000 after a step that decided 0. This includes the feedback carried from the last bit of one word into the first step of the next clock.
- R4: Each step replaces the error with (error + feedback from the preceding step − sample) modulo 2^16. The feedback used is the value before the current decision, and this delay also holds across clock boundaries.
- R5: While `en` is low, `pdm_word`, the error state and the feedback state are all zero. The clear takes effect asynchronously, without waiting for a clock edge, and the block stays cleared across clock edges while `en` stays low.
- R6: The sample present at a rising edge with `en` high is used for all `LANES` steps of that clock. The resulting word appears on `pdm_word` after that same edge and holds until the next edge.
- R7: For a constant sample x, the number of ones over many clocks approaches `LANES`·clocks·x/65536. Over 512 clocks of 8 bits, it stays within 3 of x/16.
- R8: Boundary inputs. A sample of 0xFFFF gives an all-ones word from the cleared state onward. A sample of 0 applied right after a clear gives the 8-bit word 0x03 (two leading ones), then all-zero words.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fabric clock; one output word per rising edge |
| en | input | 1 | Run enable; low clears all state and the output asynchronously |
| sample | input | 16 | Unsigned input sample, held for the whole clock |
| pdm_word | output | LANES | Parallel one-bit samples, bit 0 earliest |

## Verification
On every enabled cycle, the assertions check several properties. Bit 0 of each word must follow the comparison of the previous sample against the stored error. The stored feedback must always agree with the last bit of the registered word. A full-scale sample must yield an all-ones word, and a fall of `en` must leave word, error and feedback at zero. Only the bench's scenarios can show that the whole chain of steps within a clock, and the carry of state across clocks, reproduce a serial modulator bit for bit. The same holds for the long-run density approaching sample/65536, and for the exact start-up pattern after a clear.

// File: rtl/pdm_par_pkg.sv
package pdm_par_pkg;

   // Width of the sample, the error accumulator and the feedback value.
   localparam int unsigned PDM_W = 16;
   // Default number of bit slots resolved per fabric clock.
   localparam int unsigned PDM_DEFAULT_LANES = 8;

   typedef logic [PDM_W-1:0] pdm_val_t;

   // Modulator state handed from one step to the next.
   typedef struct packed {
      pdm_val_t err;
      pdm_val_t fb;
   } pdm_state_t;

   localparam pdm_val_t PDM_FULL  = {PDM_W{1'b1}};
   localparam pdm_val_t PDM_EMPTY = {PDM_W{1'b0}};

endpackage

// File: rtl/pdm_substep.sv
module pdm_substep
   import pdm_par_pkg::*;
(
   input  pdm_val_t   sample,
   input  pdm_state_t st_in,
   output logic       bit_out,
   output pdm_state_t st_out
);

   logic decide;

   // Decision: compare the held sample against the error before this step.
   always_comb begin
      decide = (sample >= st_in.err);
   end

   // Error update uses the feedback from the step before, not this decision.
   always_comb begin
      st_out.err = st_in.err + st_in.fb - sample;
      st_out.fb  = decide ? PDM_FULL : PDM_EMPTY;
   end

   assign bit_out = decide;

endmodule

// File: rtl/pdm_chain.sv
module pdm_chain
   import pdm_par_pkg::*;
#(
   parameter int unsigned LANES = PDM_DEFAULT_LANES
)(
   input  pdm_val_t         sample,
   input  pdm_state_t       st_seed,
   output logic [LANES-1:0] bits,
   output pdm_state_t       st_final
);

   localparam int unsigned NODES = LANES + 1;

   pdm_state_t st_link [NODES];

   assign st_link[0] = st_seed;

   // One decision step per lane; lane 0 is the earliest in time.
   for (genvar i = 0; i < LANES; i++) begin : g_lane
      pdm_substep u_step (
         .sample  (sample),
         .st_in   (st_link[i]),
         .bit_out (bits[i]),
         .st_out  (st_link[i+1])
      );
   end

   assign st_final = st_link[NODES-1];

endmodule

// File: rtl/pdm_state_reg.sv
module pdm_state_reg
   import pdm_par_pkg::*;
#(
   parameter int unsigned LANES = PDM_DEFAULT_LANES
)(
   input  logic             clk,
   input  logic             en,
   input  logic [LANES-1:0] bits_nxt,
   input  pdm_state_t       st_nxt,
   output logic [LANES-1:0] word_q,
   output pdm_state_t       st_q
);

   localparam logic [LANES-1:0] WORD_ZERO = '0;

   always_ff @(posedge clk or negedge en) begin
      if (!en) begin
         word_q    <= WORD_ZERO;
         st_q.err  <= PDM_EMPTY;
         st_q.fb   <= PDM_EMPTY;
      end else begin
         word_q    <= bits_nxt;
         st_q      <= st_nxt;
      end
   end

   // Feedback register and word register come from different chain taps.
   assert_fb_tracks_last_bit_R3: assert property (@(posedge clk) disable iff (!en)
      st_q.fb == (word_q[LANES-1] ? PDM_FULL : PDM_EMPTY))
      else $error("feedback state disagrees with last bit of word");

   // A fall of enable must have cleared everything by the next edge.
   assert_clear_on_disable_R5: assert property (@(posedge clk)
      $fell(en) |-> (word_q == WORD_ZERO && st_q.err == PDM_EMPTY && st_q.fb == PDM_EMPTY))
      else $error("state not cleared after enable fell");

endmodule

// File: rtl/pdm_par_modulator.sv
module pdm_par_modulator
   import pdm_par_pkg::*;
#(
   parameter int unsigned LANES = PDM_DEFAULT_LANES
)(
   input  logic             clk,
   input  logic             en,
   input  logic [15:0]      sample,
   output logic [LANES-1:0] pdm_word
);

   localparam int unsigned MAX_LANES = 64;
   localparam logic [LANES-1:0] WORD_ONES = '1;

   // Elaboration-time parameter checks.
   if (LANES < 1) begin : g_bad_lanes_low
      $error("LANES must be at least 1");
   end
   if (LANES > MAX_LANES) begin : g_bad_lanes_high
      $error("LANES above supported maximum");
   end
   if (PDM_W != 16) begin : g_bad_width
      $error("sample port is fixed at 16 bits");
   end

   pdm_state_t       st_q;
   pdm_state_t       st_nxt;
   logic [LANES-1:0] bits_nxt;
   logic [LANES-1:0] word_q;

   pdm_chain #(.LANES(LANES)) u_chain (
      .sample   (sample),
      .st_seed  (st_q),
      .bits     (bits_nxt),
      .st_final (st_nxt)
   );

   pdm_state_reg #(.LANES(LANES)) u_state (
      .clk      (clk),
      .en       (en),
      .bits_nxt (bits_nxt),
      .st_nxt   (st_nxt),
      .word_q   (word_q),
      .st_q     (st_q)
   );

   assign pdm_word = word_q;

   // Earliest bit of the word follows the comparison against the seed error.
   assert_first_bit_compare_R2: assert property (@(posedge clk) disable iff (!en)
      $past(en) |-> (word_q[0] == ($past(sample) >= $past(st_q.err))))
      else $error("bit 0 does not follow sample >= error");

   // Full-scale sample held for the clock yields ones in every slot.
   assert_full_scale_word_R8: assert property (@(posedge clk) disable iff (!en)
      ($past(en) && $past(sample) == 16'hFFFF) |-> (word_q == WORD_ONES))
      else $error("full-scale sample did not give all-ones word");

endmodule

// File: tb/tb_pdm_par_modulator.sv
module tb_pdm_par_modulator;

   localparam int LANES   = 8;
   localparam int DENS_CK = 512;

   typedef struct {
      logic [LANES-1:0] word;
      string            tag;
   } exp_t;

   logic             clk = 1'b0;
   logic             en  = 1'b1;
   logic [15:0]      sample = '0;
   logic [LANES-1:0] pdm_word;

   int n_cmp  = 0;
   int n_bad  = 0;
   int ones_acc = 0;
   exp_t exp_q [$];

   // Serial reference model state.
   logic [15:0] m_err = '0;
   logic [15:0] m_fb  = '0;

   always #2 clk = ~clk;

   pdm_par_modulator #(.LANES(LANES)) dut (
      .clk      (clk),
      .en       (en),
      .sample   (sample),
      .pdm_word (pdm_word)
   );

   task automatic check(input string req, input logic [LANES-1:0] act,
                        input logic [LANES-1:0] expv);
      n_cmp++;
      if (act !== expv) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h at %0t", req, act, expv, $time);
      end
   endtask

   // One serial step per bit, independent of the design's structure.
   function automatic logic [LANES-1:0] model_word(input logic [15:0] x);
      logic [LANES-1:0] w;
      for (int i = 0; i < LANES; i++) begin
         logic b;
         b = (x >= m_err);
         w[i] = b;
         m_err = m_err + m_fb - x;
         m_fb  = b ? 16'hFFFF : 16'h0000;
      end
      return w;
   endfunction

   // Driver: presents a sample for one clock and queues the expected word.
   task automatic drive(input logic [15:0] x, input string tag);
      exp_t e;
      @(negedge clk);
      en     = 1'b1;
      sample = x;
      e.word = model_word(x);
      e.tag  = tag;
      exp_q.push_back(e);
   endtask

   task automatic drain();
      while (exp_q.size() != 0) @(negedge clk);
   endtask

   // Clear: drop enable away from the edge, check at once and over an edge.
   task automatic clear_block();
      drain();
      @(negedge clk);
      #1 en = 1'b0;
      #0.5;
      check("R5 async clear", pdm_word, '0);
      @(posedge clk);
      #1 check("R5 held clear", pdm_word, '0);
      m_err = '0;
      m_fb  = '0;
   endtask

   // Monitor: pops expected words as results appear after each edge.
   always begin
      @(posedge clk);
      #1;
      if (exp_q.size() != 0) begin
         exp_t e;
         e = exp_q.pop_front();
         check(e.tag, pdm_word, e.word);
         ones_acc += $countones(pdm_word);
      end
   end

   task automatic density(input logic [15:0] x);
      int expn;
      int diff;
      clear_block();
      ones_acc = 0;
      for (int k = 0; k < DENS_CK; k++) drive(x, "R7 R1 stream");
      drain();
      expn = int'(x) / 16;
      diff = ones_acc - expn;
      n_cmp++;
      if (diff > 3 || diff < -3) begin
         n_bad++;
         $display("FAIL R7 density x=%h: actual %0d expected %0d", x, ones_acc, expn);
      end
   endtask

   initial begin
      #1 en = 1'b0;
      #1 check("R5 reset state", pdm_word, '0);
      @(posedge clk);
      #1 check("R5 reset held", pdm_word, '0);

      // R8: zero sample right after clear gives two leading ones then zeros.
      drive(16'h0000, "R8 zero first word");
      drain();
      check("R8 zero gives 03", pdm_word, 8'h03);
      drive(16'h0000, "R8 zero settles");
      drive(16'h0000, "R8 zero settles");

      // R8: full scale from cleared state.
      clear_block();
      for (int k = 0; k < 4; k++) drive(16'hFFFF, "R8 full scale");
      drain();
      check("R8 full scale ones", pdm_word, 8'hFF);

      // R1 R2 R3 R4 R6: changing samples every clock, carry across clocks.
      clear_block();
      for (int k = 0; k < 300; k++)
         drive(16'($urandom()), "R1 R2 R4 R6 random");
      for (int k = 0; k < 40; k++)
         drive((k % 2 == 0) ? 16'h0001 : 16'hFFFE, "R3 R4 alternating");
      for (int k = 0; k < 40; k++)
         drive(16'h8000, "R2 equal-compare midscale");

      // R5: clear mid-stream, then stream must restart from zero state.
      clear_block();
      for (int k = 0; k < 20; k++) drive(16'h5555, "R5 R4 restart");

      density(16'h4000);
      density(16'h8000);
      density(16'h1234);
      density(16'hC001);
      drain();

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #400000;
      n_bad++;
      n_cmp++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule